// File: doc/BRIEF.md
# Staged Self-Test Sequencer and Fault Aggregator

This block steps a multiplexer/demultiplexer channel system through a staged self-test and merges its diagnostic results into one card fault flag, a card indicator enable, a display-decode enable and a two-digit BCD display code. A self-test enable input releases a short shift-register sequencer. Each rising edge of an end-of-scan strobe advances the sequencer. The first stage loads from a minor-frame marker input.

The middle stage does two things. It releases a clear on the downstream error latch and a reset on the downstream counter. It also un-inhibits fault reporting. The last stage, together with a demultiplexer-function enable, opens the evaluation gate. The gate drives the display-decode enable when every no-error condition holds. The no-error conditions are primary-diagnostic and out-of-tolerance health, demultiplexer health, test active, and no secondary fault. A secondary fault forces the display code to the fixed value 22.

All logic runs on one clock with a synchronous active-low reset. The strobe and frame marker are registered once, and the strobe is edge detected. Every output comes from a register.

Top module: `diag_seq_aggregator`

## Requirements
- R1: After reset, and whenever the block is idle, the outputs take these values: `latch_clr`=1, `cnt_rst`=1, `card_err`=0, `card_lamp`=0, `decode_en`=0 and `disp_code`=8'h00.
- R2: When `test_en` is low at a clock edge, the sequencer empties at that edge. Every output returns to the R1 idle values on that same edge.
- R3: With `frame_mark` high, the second rising edge of `scan_end` after enable drives `latch_clr` and `cnt_rst` low. The first edge alone leaves them high. Outputs settle within three clocks of the edge.
- R4: Only a rising edge of `scan_end` advances the sequencer. Holding `scan_end` high for many clocks counts as one advance.
- R5: The first stage samples `frame_mark` at each advance. A low marker shifts a zero in, so release needs two further advances after a high marker.
- R6: While the release stage is low, `card_err`, `card_lamp` and `disp_code` stay inactive, whatever the diagnostic inputs are.
- R7: After the third advance, with `demux_fn_en` high and all conditions healthy, `decode_en`=1 and `card_lamp`=1.
- R8: While `demux_fn_en` is low, `decode_en` stays 0 even when everything is healthy.
- R9: After release, a low `prim_ok`, `tol_ok` or `demux_ok` sets `card_err`=1, `card_lamp`=0, `decode_en`=0 and `disp_code`=8'h00.
- R10: After release, a high `sec_fault` sets `card_err`=1 and `card_lamp`=0. It also sets `disp_code`=8'h22: tens digit in bits [7:4] = 2, units digit in bits [3:0] = 2.
- R11: After release with no fault, `card_err`=0, `card_lamp`=1 and `disp_code`=8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_en | input | 1 | Self-test enable; low holds sequencer empty |
| frame_mark | input | 1 | Minor-frame marker, sequencer serial input |
| scan_end | input | 1 | End-of-scan strobe, rising edge advances |
| prim_ok | input | 1 | Primary diagnostic healthy |
| tol_ok | input | 1 | Out-of-tolerance monitor healthy |
| demux_ok | input | 1 | Demultiplexer diagnostic healthy |
| sec_fault | input | 1 | Secondary diagnostic fault detected |
| demux_fn_en | input | 1 | Demultiplexer-function enable for evaluation |
| latch_clr | output | 1 | Clear to downstream error latch (active high) |
| cnt_rst | output | 1 | Reset to downstream counter (active high) |
| card_err | output | 1 | Card fault flag |
| card_lamp | output | 1 | Card indicator on (healthy under test) |
| decode_en | output | 1 | Lamp display decode enable |
| disp_code | output | 8 | Two BCD digits, tens in [7:4] |

## Verification
The assertions assume that the diagnostic level inputs are quasi-static. They are sampled directly, so a change shows at the outputs one clock later. The assertions also assume that `scan_end` and `frame_mark` come from the same clock domain, so one register stage is enough. The stimulus changes every input on the falling clock edge. Each `scan_end` pulse is held for several clocks and then released for several clocks, so each pulse yields exactly one detected edge. Health inputs are set before the strobe that releases the sequencer and are held while the outputs are sampled.

// File: rtl/diag_seq_pkg.sv
// Shared sizes and constants for the self-test sequencer and fault aggregator.
package diag_seq_pkg;
    localparam int DIGIT_W = 4;
    localparam int DIGITS  = 2;
    localparam int CODE_W  = DIGIT_W * DIGITS;
    // Forced display value on a secondary fault: every BCD digit reads 2.
    localparam logic [CODE_W-1:0] FAULT_CODE = {DIGITS{4'd2}};
    localparam logic [CODE_W-1:0] IDLE_CODE  = '0;
endpackage

// File: rtl/scan_edge_sync.sv
// Registers the end-of-scan strobe and the frame marker once and emits a
// single-cycle pulse on each rising edge of the strobe.
// Assumes both inputs are already in the clk domain.
module scan_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_in,
    input  logic mark_in,
    output logic adv,
    output logic mark_s
);
    logic scan_s;
    logic scan_d;

    // Sample the inputs and keep the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_s <= 1'b0;
            scan_d <= 1'b0;
            mark_s <= 1'b0;
        end else begin
            scan_s <= scan_in;
            scan_d <= scan_s;
            mark_s <= mark_in;
        end
    end

    // Rising-edge detect.
    assign adv = scan_s & ~scan_d;

    // R4
    adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !adv);
endmodule

// File: rtl/stage_shifter.sv
// Serial-in shift sequencer. The first stage loads the marker on each
// advance, and later stages shift. A low enable empties it on the next edge.
// Assumes adv is a single-cycle pulse.
module stage_shifter #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             adv,
    input  logic             mark,
    output logic [DEPTH-1:0] stage
);
    localparam int LAST = DEPTH - 1;

    // First stage captures the marker on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            stage[0] <= 1'b0;
        else if (adv)
            stage[0] <= mark;
    end

    genvar gi;
    generate
        for (gi = 1; gi <= LAST; gi++) begin : g_chain
            // Each later stage takes its predecessor on an advance.
            always_ff @(posedge clk) begin
                if (!rst_n || !enable)
                    stage[gi] <= 1'b0;
                else if (adv)
                    stage[gi] <= stage[gi-1];
            end
        end
    endgenerate

    // R2
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (stage == '0));
    // R4
    hold_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !adv) |=> $stable(stage));
endmodule

// File: rtl/fault_combiner.sv
// Merges the diagnostic conditions under the sequencer stages into the
// registered fault flag, indicator, decode enable and BCD display code.
// Assumes diagnostic levels are quasi-static relative to clk.
module fault_combiner
    import diag_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              stage_rel,
    input  logic              stage_eval,
    input  logic              prim_ok,
    input  logic              tol_ok,
    input  logic              demux_ok,
    input  logic              sec_fault,
    input  logic              demux_fn_en,
    output logic              latch_clr,
    output logic              cnt_rst,
    output logic              card_err,
    output logic              card_lamp,
    output logic              decode_en,
    output logic [CODE_W-1:0] disp_code
);
    logic active;
    logic no_err;
    logic eval_gate;
    logic [CODE_W-1:0] code_d;

    // Form the no-error term and the evaluation gate.
    always_comb begin
        active    = test_en & stage_rel;
        no_err    = (prim_ok & tol_ok) & demux_ok & test_en & ~sec_fault;
        eval_gate = active & stage_eval & demux_fn_en;
        code_d    = (active && sec_fault) ? FAULT_CODE : IDLE_CODE;
    end

    // Register every output; idle values apply in reset and when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_clr <= 1'b1;
            cnt_rst   <= 1'b1;
            card_err  <= 1'b0;
            card_lamp <= 1'b0;
            decode_en <= 1'b0;
            disp_code <= IDLE_CODE;
        end else begin
            latch_clr <= ~active;
            cnt_rst   <= ~active;
            card_err  <= active & ~no_err;
            card_lamp <= active & no_err;
            decode_en <= eval_gate & no_err;
            disp_code <= code_d;
        end
    end

    // R6
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_en && stage_rel) |=> (!card_err && !card_lamp && disp_code == IDLE_CODE));
    // R10
    forced_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && stage_rel && sec_fault) |=> (disp_code == FAULT_CODE && card_err));
    // R9
    code_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_code != IDLE_CODE) |-> card_err);
    // R7
    decode_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decode_en |-> (card_lamp && !card_err && !latch_clr));
    // R8
    fn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !demux_fn_en |=> !decode_en);
endmodule

// File: rtl/diag_seq_aggregator.sv
// Top level: staged self-test sequencer plus fault aggregation.
// Stage SEQ_DEPTH-2 releases clears and un-inhibits reporting; the last
// stage opens evaluation. All outputs are registered.
module diag_seq_aggregator
    import diag_seq_pkg::*;
#(
    parameter int SEQ_DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              frame_mark,
    input  logic              scan_end,
    input  logic              prim_ok,
    input  logic              tol_ok,
    input  logic              demux_ok,
    input  logic              sec_fault,
    input  logic              demux_fn_en,
    output logic              latch_clr,
    output logic              cnt_rst,
    output logic              card_err,
    output logic              card_lamp,
    output logic              decode_en,
    output logic [CODE_W-1:0] disp_code
);
    localparam int REL_IDX  = SEQ_DEPTH - 2;
    localparam int EVAL_IDX = SEQ_DEPTH - 1;

    logic                 adv;
    logic                 mark_s;
    logic [SEQ_DEPTH-1:0] stage;

    scan_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_in (scan_end),
        .mark_in (frame_mark),
        .adv     (adv),
        .mark_s  (mark_s)
    );

    stage_shifter #(.DEPTH(SEQ_DEPTH)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (test_en),
        .adv    (adv),
        .mark   (mark_s),
        .stage  (stage)
    );

    fault_combiner u_comb (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_en     (test_en),
        .stage_rel   (stage[REL_IDX]),
        .stage_eval  (stage[EVAL_IDX]),
        .prim_ok     (prim_ok),
        .tol_ok      (tol_ok),
        .demux_ok    (demux_ok),
        .sec_fault   (sec_fault),
        .demux_fn_en (demux_fn_en),
        .latch_clr   (latch_clr),
        .cnt_rst     (cnt_rst),
        .card_err    (card_err),
        .card_lamp   (card_lamp),
        .decode_en   (decode_en),
        .disp_code   (disp_code)
    );

    // R2
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (latch_clr && cnt_rst && !card_err && !card_lamp && !decode_en));
    // R3
    release_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_clr == cnt_rst);
endmodule

// File: tb/diag_seq_aggregator_tb.sv
module diag_seq_aggregator_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_en = 1'b0, frame_mark = 1'b0, scan_end = 1'b0;
    logic prim_ok = 1'b1, tol_ok = 1'b1, demux_ok = 1'b1;
    logic sec_fault = 1'b0, demux_fn_en = 1'b1;
    logic latch_clr, cnt_rst, card_err, card_lamp, decode_en;
    logic [7:0] disp_code;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    diag_seq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .frame_mark(frame_mark),
        .scan_end(scan_end), .prim_ok(prim_ok), .tol_ok(tol_ok),
        .demux_ok(demux_ok), .sec_fault(sec_fault), .demux_fn_en(demux_fn_en),
        .latch_clr(latch_clr), .cnt_rst(cnt_rst), .card_err(card_err),
        .card_lamp(card_lamp), .decode_en(decode_en), .disp_code(disp_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pack the outputs for compact compares: {clr,rst,err,lamp,dec,code}.
    function automatic logic [12:0] outs();
        return {latch_clr, cnt_rst, card_err, card_lamp, decode_en, disp_code};
    endfunction

    localparam logic [12:0] IDLE = {5'b11000, 8'h00};

    task automatic pulse();
        scan_end = 1'b1; ticks(4);
        scan_end = 1'b0; ticks(4);
    endtask

    task automatic healthy();
        prim_ok = 1; tol_ok = 1; demux_ok = 1; sec_fault = 0; demux_fn_en = 1;
    endtask

    task automatic start();
        test_en = 0; ticks(2);
        frame_mark = 1; test_en = 1; ticks(2);
    endtask

    task automatic t_reset();
        rst_n = 0; ticks(3);
        chk("R1 reset idle", outs(), IDLE);
        rst_n = 1; ticks(2);
        chk("R1 idle after reset", outs(), IDLE);
    endtask

    task automatic t_sequence();
        healthy(); start();
        pulse();
        chk("R3 one edge no release", {latch_clr, cnt_rst}, 2'b11);
        chk("R6 inhibited before release", {card_err, card_lamp}, 2'b00);
        pulse();
        chk("R3 release after second edge", {latch_clr, cnt_rst}, 2'b00);
        chk("R11 healthy lamp", outs(), {5'b00010, 8'h00});
        pulse();
        chk("R7 decode after third edge", outs(), {5'b00011, 8'h00});
        test_en = 0; @(posedge clk); #1;
        chk("R2 idle one clock after disable", outs(), IDLE);
    endtask

    task automatic t_hold();
        healthy(); start();
        scan_end = 1; ticks(20);
        chk("R4 long high is one edge", latch_clr, 1'b1);
        scan_end = 0; ticks(4);
        pulse();
        chk("R4 second edge releases", latch_clr, 1'b0);
    endtask

    task automatic t_mark();
        healthy(); start();
        frame_mark = 0;
        pulse(); pulse();
        chk("R5 low marker no release", latch_clr, 1'b1);
        frame_mark = 1; pulse();
        chk("R5 one high load not yet", latch_clr, 1'b1);
        pulse();
        chk("R5 release after two more", latch_clr, 1'b0);
    endtask

    task automatic t_inhibit();
        healthy(); sec_fault = 1; prim_ok = 0; start();
        pulse();
        chk("R6 faults inhibited", outs(), IDLE);
        pulse();
        chk("R10 sec fault code 22", outs(), {5'b00100, 8'h22});
    endtask

    task automatic t_fn_gate();
        healthy(); demux_fn_en = 0; start();
        pulse(); pulse(); pulse();
        chk("R8 decode blocked", decode_en, 1'b0);
        chk("R8 lamp still on", card_lamp, 1'b1);
        demux_fn_en = 1; ticks(2);
        chk("R7 decode once enabled", decode_en, 1'b1);
    endtask

    task automatic t_primary();
        healthy(); start();
        pulse(); pulse(); pulse();
        prim_ok = 0; ticks(2);
        chk("R9 primary fault", outs(), {5'b00100, 8'h00});
        prim_ok = 1; tol_ok = 0; ticks(2);
        chk("R9 tolerance fault", outs(), {5'b00100, 8'h00});
        tol_ok = 1; demux_ok = 0; ticks(2);
        chk("R9 demux fault", outs(), {5'b00100, 8'h00});
        demux_ok = 1; sec_fault = 1; ticks(2);
        chk("R10 code 22 in eval", outs(), {5'b00100, 8'h22});
        sec_fault = 0; ticks(2);
        chk("R11 back to healthy", outs(), {5'b00011, 8'h00});
        test_en = 0; ticks(1);
        chk("R2 disable from eval", outs(), IDLE);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_hold();
        t_mark();
        t_inhibit();
        t_fn_gate();
        t_primary();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule